// File: doc/BRIEF.md
# Serial Flash Controller Status Front-End

This block is the register-facing half of a four-lane serial flash controller. It holds the control word that the command sequencer reads. It also keeps the sticky event flags raised by the sequencer and the byte FIFO that carries payload between software (or a DMA engine) and the sequencer. Software reaches the FIFO one byte at a time through a data register. The sequencer reaches it through its own push and pop strobes, and the direction follows the sequencer's read-mode input.

Four word-indexed registers sit on a simple single-cycle bus: control (index 0), status (index 1), flag clear (index 2) and data (index 3). Read data is combinational, and writes and pops take effect on the clock edge. An abort request in the control word empties the FIFO at once. The request stays visible until the sequencer reports that it is idle, then it clears itself and marks the transfer as complete. An interrupt and a DMA request are formed from the flags.

Top module: `sfc_status_front`

## Requirements
- R1: After reset the control word reads 0, status bits 0, 1, 3, 4 and 5 read 0, the level field reads 0, and irq and dma_req are low.
- R2: Control bits [4:0], the threshold field starting at bit 8 (log2 of the FIFO depth wide), bits [20:16] and [31:24] hold what is written. All other bits read 0. Bit 1 (abort) can be set by a bus write but not cleared by one.
- R3: A write to the data register pushes bus_wdata[7:0] when the FIFO is not full, and the write is dropped when it is full. A read returns the oldest byte, and in read mode it also pops that byte. A read of an empty FIFO returns 0.
- R4: Status bits [13:8] give the number of bytes currently held in the FIFO.
- R5: Status bit 2 (threshold) is live. When seq_read_mode is 1 it is set when the level is at least threshold+1. When seq_read_mode is 0 it is set when the free space is at least threshold+1.
- R6: Status bits 0 (error, from seq_err), 1 (complete, from seq_done), 3 (match, from seq_match) and 4 (timeout, from seq_timeout) are sticky. Writing 1 to the same bit of the flag-clear register clears the flag, and writing 0 does nothing. A set and a clear in the same cycle leave the flag set.
- R7: Status bit 5 (busy) is high while seq_busy is high or an abort is pending.
- R8: A write of 1 to control bit 1 empties the FIFO on that edge, and pushes are refused while the abort is pending. On the first edge where the abort is pending and seq_busy is low, the bit clears and the complete flag is set.
- R9: irq is the OR over the flags of each flag ANDed with its enable. The enables are control bit 16 (error), 17 (complete), 18 (threshold), 19 (match) and 20 (timeout).
- R10: dma_req is high exactly when control bit 2 and the threshold flag are both set.
- R11: In read mode, seq_push stores seq_push_data. In write mode, seq_pop_data shows the oldest byte and seq_pop removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| seq_busy | input | 1 | Sequencer has a command in progress |
| seq_done | input | 1 | Transfer-complete event pulse |
| seq_err | input | 1 | Transfer-error event pulse |
| seq_match | input | 1 | Status-match event pulse |
| seq_timeout | input | 1 | Timeout event pulse |
| seq_read_mode | input | 1 | 1 = flash-to-FIFO transfer, 0 = FIFO-to-flash |
| seq_push | input | 1 | Sequencer stores a received byte (read mode) |
| seq_push_data | input | 8 | Received byte |
| seq_pop | input | 1 | Sequencer takes a byte to send (write mode) |
| seq_pop_data | output | 8 | Oldest FIFO byte |
| fifo_level | output | $clog2(FIFO_DEPTH)+1 | Bytes held in the FIFO |
| ctrl_word | output | 32 | Control word including the pending abort bit |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA service request |

## Verification
The FIFO path is driven with short ordered byte runs and with a run of one more byte than the depth, which separates a correct order and drop-on-full from reordering or overwriting. A vector table sets the fill level one below and exactly at threshold+1 in both modes, including zero and maximum thresholds. This distinguishes an off-by-one compare and a swapped level/free-space comparison. Flag events are pulsed singly, against zero-writes and against a clear in the same cycle. An abort is issued with the sequencer held busy and then released, which tests the flush, the blocked push and the self-clear timing apart.

// File: rtl/sfc_pkg.sv
`timescale 1ns/1ps
package sfc_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_STAT = 2'd1,
      SEL_FCLR = 2'd2,
      SEL_DATA = 2'd3
   } reg_sel_e;

   localparam int unsigned NUM_FLAGS   = 5;
   localparam int unsigned FLG_ERR     = 0;
   localparam int unsigned FLG_DONE    = 1;
   localparam int unsigned FLG_THR     = 2;
   localparam int unsigned FLG_MATCH   = 3;
   localparam int unsigned FLG_TMO     = 4;
   localparam int unsigned ST_BUSY     = 5;
   localparam int unsigned ST_LVL_LSB  = 8;

   localparam int unsigned CT_ABORT    = 1;
   localparam int unsigned CT_DMA      = 2;
   localparam int unsigned CT_THR_LSB  = 8;
   localparam int unsigned CT_IEN_LSB  = 16;
endpackage

// File: rtl/sfc_byte_fifo.sv
`timescale 1ns/1ps
module sfc_byte_fifo #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned DW    = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush_i,
   input  logic                     push_i,
   input  logic [DW-1:0]            push_data_i,
   input  logic                     pop_i,
   output logic [DW-1:0]            head_o,
   output logic [$clog2(DEPTH):0]   level_o
);
   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam int unsigned LVL_W = PTR_W + 1;

   if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("sfc_byte_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [DW-1:0]    mem_q [DEPTH];
   logic [PTR_W-1:0] wptr_q, rptr_q;
   logic [LVL_W-1:0] lvl_q;
   logic             do_push, do_pop, empty, full;

   assign empty   = (lvl_q == '0);
   assign full    = (lvl_q == LVL_W'(DEPTH));
   assign do_push = push_i && !full && !flush_i;
   assign do_pop  = pop_i && !empty && !flush_i;

   always_ff @(posedge clk) begin
      if (do_push) mem_q[wptr_q] <= push_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         lvl_q  <= '0;
      end else if (flush_i) begin
         wptr_q <= '0;
         rptr_q <= '0;
         lvl_q  <= '0;
      end else begin
         if (do_push) wptr_q <= wptr_q + 1'b1;
         if (do_pop)  rptr_q <= rptr_q + 1'b1;
         lvl_q <= lvl_q + LVL_W'(do_push) - LVL_W'(do_pop);
      end
   end

   assign head_o  = empty ? '0 : mem_q[rptr_q];
   assign level_o = lvl_q;

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_q <= LVL_W'(DEPTH));
   assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i && !flush_i && full) |=> full);
   assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> empty);
endmodule

// File: rtl/sfc_flag_unit.sv
`timescale 1ns/1ps
module sfc_flag_unit #(
   parameter int unsigned NF     = 5,
   parameter int unsigned LIVE_I = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] set_i,
   input  logic [NF-1:0] clr_i,
   input  logic [NF-1:0] ien_i,
   input  logic          dma_en_i,
   output logic [NF-1:0] flags_o,
   output logic          irq_o,
   output logic          dma_req_o
);
   if (LIVE_I >= NF) begin : g_bad_idx
      $error("sfc_flag_unit: LIVE_I out of range");
   end

   for (genvar i = 0; i < NF; i++) begin : g_flag
      if (i == LIVE_I) begin : g_live
         assign flags_o[i] = set_i[i] && !clr_i[i];
      end else begin : g_sticky
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= set_i[i] | (flag_q & ~clr_i[i]);
         end
         assign flags_o[i] = flag_q;

         assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flags_o[i]);
         assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[i] && !clr_i[i]) |=> flags_o[i]);
      end
   end

   assign irq_o     = |(flags_o & ien_i);
   assign dma_req_o = dma_en_i && flags_o[LIVE_I];
endmodule

// File: rtl/sfc_status_front.sv
`timescale 1ns/1ps
module sfc_status_front
   import sfc_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bus_en,
   input  logic                          bus_we,
   input  logic [1:0]                    bus_addr,
   input  logic [31:0]                   bus_wdata,
   output logic [31:0]                   bus_rdata,
   input  logic                          seq_busy,
   input  logic                          seq_done,
   input  logic                          seq_err,
   input  logic                          seq_match,
   input  logic                          seq_timeout,
   input  logic                          seq_read_mode,
   input  logic                          seq_push,
   input  logic [7:0]                    seq_push_data,
   input  logic                          seq_pop,
   output logic [7:0]                    seq_pop_data,
   output logic [$clog2(FIFO_DEPTH):0]   fifo_level,
   output logic [31:0]                   ctrl_word,
   output logic                          irq,
   output logic                          dma_req
);
   localparam int unsigned THR_W = $clog2(FIFO_DEPTH);
   localparam int unsigned LVL_W = THR_W + 1;
   localparam logic [31:0] CTRL_WMASK =
      32'hFF1F_001D | (32'((1 << THR_W) - 1) << CT_THR_LSB);

   if (FIFO_DEPTH < 2 || FIFO_DEPTH > 32 || (1 << THR_W) != FIFO_DEPTH) begin : g_bad_depth
      $error("sfc_status_front: FIFO_DEPTH must be a power of two in 2..32");
   end

   reg_sel_e sel;
   logic wr_ctrl, wr_fclr, wr_data, rd_data;
   logic [31:0] ctrl_q;
   logic abort_q, abort_set, abort_done, flush;
   logic fifo_push, fifo_pop;
   logic [7:0] fifo_wbyte, head;
   logic [LVL_W-1:0] level;
   logic [THR_W-1:0] thr;
   logic thr_hit;
   logic [NUM_FLAGS-1:0] set_vec, clr_vec, flags;
   logic [31:0] stat_word;

   assign sel     = reg_sel_e'(bus_addr);
   assign wr_ctrl = bus_en &&  bus_we && sel == SEL_CTRL;
   assign wr_fclr = bus_en &&  bus_we && sel == SEL_FCLR;
   assign wr_data = bus_en &&  bus_we && sel == SEL_DATA;
   assign rd_data = bus_en && !bus_we && sel == SEL_DATA;

   // control word; abort kept apart because hardware owns its clearing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_WMASK & ~(32'd1 << CT_ABORT);
   end

   assign abort_set  = wr_ctrl && bus_wdata[CT_ABORT];
   assign abort_done = abort_q && !seq_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) abort_q <= 1'b0;
      else        abort_q <= abort_set | (abort_q & seq_busy);
   end

   assign flush     = abort_q || abort_set;
   assign ctrl_word = ctrl_q | (32'(abort_q) << CT_ABORT);

   // FIFO direction follows the sequencer's transfer mode
   assign fifo_push  = seq_read_mode ? seq_push : wr_data;
   assign fifo_wbyte = seq_read_mode ? seq_push_data : bus_wdata[7:0];
   assign fifo_pop   = seq_read_mode ? rd_data : seq_pop;

   sfc_byte_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) i_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush_i     (flush),
      .push_i      (fifo_push),
      .push_data_i (fifo_wbyte),
      .pop_i       (fifo_pop),
      .head_o      (head),
      .level_o     (level)
   );

   assign thr     = ctrl_q[CT_THR_LSB +: THR_W];
   assign thr_hit = seq_read_mode ? (level > {1'b0, thr})
                                  : ((LVL_W'(FIFO_DEPTH) - level) > {1'b0, thr});

   always_comb begin
      set_vec            = '0;
      set_vec[FLG_ERR]   = seq_err;
      set_vec[FLG_DONE]  = seq_done || abort_done;
      set_vec[FLG_THR]   = thr_hit;
      set_vec[FLG_MATCH] = seq_match;
      set_vec[FLG_TMO]   = seq_timeout;
      clr_vec            = wr_fclr ? bus_wdata[NUM_FLAGS-1:0] : '0;
      clr_vec[FLG_THR]   = 1'b0;
   end

   sfc_flag_unit #(.NF(NUM_FLAGS), .LIVE_I(FLG_THR)) i_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (set_vec),
      .clr_i     (clr_vec),
      .ien_i     (ctrl_q[CT_IEN_LSB +: NUM_FLAGS]),
      .dma_en_i  (ctrl_q[CT_DMA]),
      .flags_o   (flags),
      .irq_o     (irq),
      .dma_req_o (dma_req)
   );

   always_comb begin
      stat_word                         = '0;
      stat_word[NUM_FLAGS-1:0]          = flags;
      stat_word[ST_BUSY]                = seq_busy || abort_q;
      stat_word[ST_LVL_LSB +: LVL_W]    = level;
   end

   always_comb begin
      unique case (sel)
         SEL_CTRL: bus_rdata = ctrl_word;
         SEL_STAT: bus_rdata = stat_word;
         SEL_FCLR: bus_rdata = '0;
         default:  bus_rdata = {24'd0, head};
      endcase
   end

   assign seq_pop_data = head;
   assign fifo_level   = level;

   assert_abort_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_q && !seq_busy && !abort_set) |=> (!ctrl_word[CT_ABORT] && flags[FLG_DONE]));
   assert_abort_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_q && seq_busy) |=> ctrl_word[CT_ABORT]);
   assert_dma_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> (ctrl_q[CT_DMA] && thr_hit));
endmodule

// File: tb/test_sfc_status_front.sv
`timescale 1ns/1ps
module test_sfc_status_front;
   localparam int unsigned DEPTH = 16;
   localparam int unsigned NVEC  = 10;
   // vector: {read_mode, thr[3:0], fill[4:0], expected threshold flag}
   localparam logic [10:0] VEC [NVEC] = '{
      {1'b1, 4'd3,  5'd3,  1'b0},
      {1'b1, 4'd3,  5'd4,  1'b1},
      {1'b1, 4'd0,  5'd0,  1'b0},
      {1'b1, 4'd0,  5'd1,  1'b1},
      {1'b0, 4'd3,  5'd12, 1'b1},
      {1'b0, 4'd3,  5'd13, 1'b0},
      {1'b0, 4'd15, 5'd0,  1'b1},
      {1'b0, 4'd15, 5'd1,  1'b0},
      {1'b1, 4'd15, 5'd16, 1'b1},
      {1'b1, 4'd15, 5'd15, 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_en = 1'b0, bus_we = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic seq_busy = 1'b0, seq_done = 1'b0, seq_err = 1'b0;
   logic seq_match = 1'b0, seq_timeout = 1'b0, seq_read_mode = 1'b0;
   logic seq_push = 1'b0, seq_pop = 1'b0;
   logic [7:0] seq_push_data = '0;
   logic [7:0] seq_pop_data;
   logic [4:0] fifo_level;
   logic [31:0] ctrl_word;
   logic irq, dma_req;

   int n_checks = 0, n_fail = 0;
   bit finished = 1'b0;
   logic [31:0] rd;

   always #2.5 clk = ~clk;

   sfc_status_front #(.FIFO_DEPTH(DEPTH)) i_sfc_status_front (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .seq_busy(seq_busy), .seq_done(seq_done), .seq_err(seq_err),
      .seq_match(seq_match), .seq_timeout(seq_timeout),
      .seq_read_mode(seq_read_mode), .seq_push(seq_push),
      .seq_push_data(seq_push_data), .seq_pop(seq_pop),
      .seq_pop_data(seq_pop_data), .fifo_level(fifo_level),
      .ctrl_word(ctrl_word), .irq(irq), .dma_req(dma_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_en = 1'b0;
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: seq_err = 1'b1;
         1: seq_done = 1'b1;
         3: seq_match = 1'b1;
         4: seq_timeout = 1'b1;
         5: seq_push = 1'b1;
         default: seq_pop = 1'b1;
      endcase
      @(negedge clk);
      seq_err = 0; seq_done = 0; seq_match = 0; seq_timeout = 0; seq_push = 0; seq_pop = 0;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   initial begin
      #200000;
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state (write mode, empty: threshold flag set by R5)
      bus_read(2'd0, rd); chk("R1 ctrl", rd, 32'h0);
      bus_read(2'd1, rd); chk("R1 status", rd, 32'h0000_0004);
      chk("R1 irq/dma", {30'd0, irq, dma_req}, 32'h0);

      // R2 control fields, R9/R10 with all enables
      bus_write(2'd0, 32'hFFFF_FFFD);
      bus_read(2'd0, rd); chk("R2 ctrl mask", rd, 32'hFF1F_0F1D);
      chk("R9 irq all enables", {31'd0, irq}, 32'd1);
      chk("R10 dma_req", {31'd0, dma_req}, 32'd1);
      bus_write(2'd0, 32'h0);
      chk("R10 dma_req off", {31'd0, dma_req}, 32'd0);

      // R3/R4 ordered bytes
      bus_write(2'd3, 32'h0000_00A1);
      bus_write(2'd3, 32'hFFFF_FFB2);
      bus_write(2'd3, 32'h0000_00C3);
      bus_read(2'd1, rd); chk("R4 level 3", rd, 32'h0000_0304);
      seq_read_mode = 1'b1;
      bus_read(2'd3, rd); chk("R3 byte0", rd, 32'hA1);
      bus_read(2'd3, rd); chk("R3 byte1", rd, 32'hB2);
      bus_read(2'd3, rd); chk("R3 byte2", rd, 32'hC3);
      bus_read(2'd3, rd); chk("R3 empty read", rd, 32'h0);
      bus_read(2'd1, rd); chk("R4 level 0", rd[13:8], 32'h0);

      // R3 full plus one
      seq_read_mode = 1'b0;
      for (int i = 0; i < 17; i++) bus_write(2'd3, 32'h10 + i);
      bus_read(2'd1, rd); chk("R3 full status", rd, 32'h0000_1000);
      seq_read_mode = 1'b1;
      for (int i = 0; i < 16; i++) begin
         bus_read(2'd3, rd); chk("R3 full order", rd, 32'h10 + i);
      end
      bus_read(2'd3, rd); chk("R3 dropped byte", rd, 32'h0);
      seq_read_mode = 1'b0;

      // R6 sticky flags
      pulse(0);
      bus_read(2'd1, rd); chk("R6 error set", rd[4:0], 32'h05);
      bus_write(2'd2, 32'h0);
      bus_read(2'd1, rd); chk("R6 zero write", rd[4:0], 32'h05);
      bus_write(2'd2, 32'h1);
      bus_read(2'd1, rd); chk("R6 error clear", rd[4:0], 32'h04);
      pulse(1); pulse(3); pulse(4);
      bus_read(2'd1, rd); chk("R6 done/match/tmo", rd[4:0], 32'h1E);
      bus_write(2'd2, 32'h1B);
      bus_read(2'd1, rd); chk("R6 clear all", rd[4:0], 32'h04);
      @(negedge clk);
      seq_err = 1'b1; bus_en = 1'b1; bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = 32'h1;
      @(negedge clk);
      seq_err = 1'b0; bus_en = 1'b0; bus_we = 1'b0;
      bus_read(2'd1, rd); chk("R6 set wins", rd[0], 32'h1);
      bus_write(2'd2, 32'h1);

      // R9 single enables
      bus_write(2'd0, 32'h0002_0000);
      chk("R9 no flag", {31'd0, irq}, 32'd0);
      pulse(1);
      chk("R9 done irq", {31'd0, irq}, 32'd1);
      bus_write(2'd2, 32'h2);
      chk("R9 irq cleared", {31'd0, irq}, 32'd0);
      bus_write(2'd0, 32'h0004_0000);
      chk("R9 threshold irq", {31'd0, irq}, 32'd1);
      bus_write(2'd0, 32'h0);

      // R7 busy, R8 abort
      @(negedge clk); seq_busy = 1'b1;
      bus_read(2'd1, rd); chk("R7 busy", rd, 32'h0000_0024);
      bus_write(2'd3, 32'h11); bus_write(2'd3, 32'h22); bus_write(2'd3, 32'h33);
      bus_write(2'd0, 32'h2);
      bus_read(2'd0, rd); chk("R8 abort pending", rd, 32'h2);
      bus_read(2'd1, rd); chk("R8 flushed", rd, 32'h0000_0024);
      bus_write(2'd3, 32'h77);
      bus_read(2'd1, rd); chk("R8 push blocked", rd, 32'h0000_0024);
      bus_write(2'd0, 32'h0);
      bus_read(2'd0, rd); chk("R2 abort not cleared by write", rd, 32'h2);
      @(negedge clk); seq_busy = 1'b0;
      @(negedge clk);
      bus_read(2'd0, rd); chk("R8 abort released", rd, 32'h0);
      bus_read(2'd1, rd); chk("R8 done set, busy low", rd, 32'h0000_0006);
      bus_write(2'd2, 32'h2);

      // R11 sequencer side
      seq_read_mode = 1'b1;
      seq_push_data = 8'h5A; pulse(5);
      seq_push_data = 8'h6B; pulse(5);
      bus_read(2'd1, rd); chk("R11 pushed level", rd, 32'h0000_0204);
      bus_read(2'd3, rd); chk("R11 bus pop", rd, 32'h5A);
      seq_read_mode = 1'b0;
      #1 chk("R11 pop data", {24'd0, seq_pop_data}, 32'h6B);
      pulse(6);
      bus_read(2'd1, rd); chk("R11 popped", rd, 32'h0000_0004);

      // R5/R10 threshold vectors
      for (int v = 0; v < NVEC; v++) begin
         bus_write(2'd0, (32'(VEC[v][9:6]) << 8) | 32'h4);
         seq_read_mode = 1'b0;
         for (int b = 0; b < int'(VEC[v][5:1]); b++) bus_write(2'd3, 32'(b));
         @(negedge clk);
         seq_read_mode = VEC[v][10];
         #1;
         bus_read(2'd1, rd);
         chk("R5 threshold vector", {27'd0, rd[13:8] == 6'(VEC[v][5:1]), 3'd0, rd[2]},
             {27'd0, 1'b1, 3'd0, VEC[v][0]});
         chk("R10 dma vector", {31'd0, dma_req}, {31'd0, VEC[v][0]});
         bus_write(2'd0, 32'h2);
         bus_write(2'd2, 32'h2);
         seq_read_mode = 1'b0;
      end

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule